// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Controller

This block resolves read-after-write dependences for a five-stage, in-order integer pipeline. Operands are read during decode and every result is written back in the fifth stage, so write-after-read and write-after-write conflicts cannot arise; only true dependences need handling. For the instruction now in execute, the block compares each source register number against the destination of the older instructions in the memory and writeback stages. It then steers the two ALU operand multiplexers so that a fresh result is taken from the pipeline instead of the stale register-file copy.

A loaded value is only available at the end of the memory stage, so it cannot reach an instruction that enters execute right behind the load. When the instruction in decode needs the destination of a load that sits in execute, the block freezes the program counter and the fetch/decode register for one cycle and kills the valid bit entering execute, which places a single bubble. After that cycle the load sits in writeback and its data is bypassed from there. The block also flags when a decode-stage read hits the register being written back in the same cycle, so the register-file read path can return the new value.

Top module: `fwd_hazard_unit`

## Requirements
- R1: Each operand select uses the code 2'b00 for the register file, 2'b01 for the memory-stage result and 2'b10 for the writeback-stage result; a source that matches the memory-stage destination selects 2'b01.
- R2: A source that matches the writeback-stage destination and not the memory-stage one selects 2'b10.
- R3: When a source matches both the memory-stage and the writeback-stage destination, the memory-stage result (2'b01) wins.
- R4: A producer counts only when its valid bit and register-write enable are both set and its destination is not register 0; register 0 always selects 2'b00.
- R5: While the execute-stage valid bit is low, both operand selects are 2'b00.
- R6: A decode-stage bypass flag is raised for an operand when the writeback producer is valid, writes a register, has a nonzero destination and that destination equals the decode source.
- R7: When execute holds a valid load with write enable and nonzero destination equal to a decode source whose use flag is set, the PC hold, fetch/decode hold and execute bubble strobes are all high in that cycle.
- R8: No stall is requested when the matching decode source has its use flag low, or when the instruction in execute is not a load.
- R9: No stall is requested in the cycle right after a stall cycle, so each load-use dependence costs exactly one bubble.
- R10: Reset clears the record of a previous stall; with no valid producers after reset all selects are 2'b00, bypass flags are low and no stall is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1 | input | REG_W | First source register of the instruction in decode |
| id_rs2 | input | REG_W | Second source register of the instruction in decode |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source (store data, branch compare) |
| ex_valid | input | 1 | Execute stage holds a valid instruction |
| ex_rs1 | input | REG_W | First source register of the instruction in execute |
| ex_rs2 | input | REG_W | Second source register of the instruction in execute |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_rd | input | REG_W | Destination register of the instruction in execute |
| mem_valid | input | 1 | Memory stage holds a valid instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_rd | input | REG_W | Memory-stage destination register |
| wb_valid | input | 1 | Writeback stage holds a valid instruction |
| wb_wen | input | 1 | Writeback instruction writes a register |
| wb_rd | input | REG_W | Writeback destination register |
| fwd_sel_a | output | 2 | Operand A select (00 register file, 01 memory, 10 writeback) |
| fwd_sel_b | output | 2 | Operand B select, same coding |
| id_wb_byp_a | output | 1 | Decode read of operand A must take the writeback value |
| id_wb_byp_b | output | 1 | Decode read of operand B must take the writeback value |
| hold_pc | output | 1 | Freeze the program counter this cycle |
| hold_ifid | output | 1 | Freeze the fetch/decode register this cycle |
| bubble_ex | output | 1 | Clear the valid bit entering execute this cycle |

## Verification
The assertions take for granted that the stage inputs are settled and known at each rising edge and that reset is asserted before the first meaningful cycle; they put no other constraint on the stage inputs, since the block must give a defined answer for any mix of valid bits, write enables and register numbers. The stimulus keeps within that by changing inputs only on the falling edge and by drawing register numbers from a small range including register 0, so that matches, double matches and zero destinations happen often. Runs of repeated load-use patterns make sure that the one-bubble rule is exercised both right after a stall and across a reset.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Operand source selection; the datapath multiplexer decodes these codes.
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MEM = 2'b01,
    FWD_WB  = 2'b10
  } fwd_sel_e;

  // Two ALU operands per instruction.
  localparam int NUM_OPS = 2;

endpackage

// File: rtl/hzd_reg_match.sv
module hzd_reg_match #(
  parameter int REG_W = 5
) (
  input  logic             prod_valid,
  input  logic             prod_wen,
  input  logic [REG_W-1:0] prod_rd,
  input  logic [REG_W-1:0] src_rs,
  output logic             hit
);

  // A producer is meaningful only if live, writing, and not the zero register.
  always_comb begin
    hit = prod_valid && prod_wen && (prod_rd != '0) && (prod_rd == src_rs);
  end

endmodule

// File: rtl/hzd_operand_ctl.sv
module hzd_operand_ctl #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ex_valid,
  input  logic [REG_W-1:0] src_rs,
  input  logic             mem_valid,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             wb_valid,
  input  logic             wb_wen,
  input  logic [REG_W-1:0] wb_rd,
  output fwd_pkg::fwd_sel_e sel
);
  import fwd_pkg::*;

  logic mem_hit;
  logic wb_hit;

  hzd_reg_match #(.REG_W(REG_W)) u_mem_match (
    .prod_valid(mem_valid),
    .prod_wen  (mem_wen),
    .prod_rd   (mem_rd),
    .src_rs    (src_rs),
    .hit       (mem_hit)
  );

  hzd_reg_match #(.REG_W(REG_W)) u_wb_match (
    .prod_valid(wb_valid),
    .prod_wen  (wb_wen),
    .prod_rd   (wb_rd),
    .src_rs    (src_rs),
    .hit       (wb_hit)
  );

  // Youngest producer first: memory stage outranks writeback.
  always_comb begin
    sel = FWD_RF;
    if (ex_valid) begin
      if (mem_hit) begin
        sel = FWD_MEM;
      end else if (wb_hit) begin
        sel = FWD_WB;
      end
    end
  end

  AST_MEM_SRC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == FWD_MEM) |-> (mem_rd == src_rs && mem_valid && mem_wen)); // R1
  AST_WB_SRC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == FWD_WB) |-> (wb_rd == src_rs && wb_valid && wb_wen)); // R2
  AST_MEM_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && mem_valid && mem_wen && mem_rd != '0 && mem_rd == src_rs
     && wb_valid && wb_wen && wb_rd == src_rs) |-> (sel == FWD_MEM)); // R3
  AST_NO_ZERO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rs == '0) |-> (sel == FWD_RF)); // R4
  AST_IDLE_EX: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_valid) |-> (sel == FWD_RF)); // R5

endmodule

// File: rtl/hzd_loaduse_det.sv
module hzd_loaduse_det #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0][REG_W-1:0]   id_rs,
  input  logic [NUM_SRC-1:0]              id_use,
  input  logic                            ex_valid,
  input  logic                            ex_wen,
  input  logic                            ex_is_load,
  input  logic [REG_W-1:0]                ex_rd,
  output logic                            stall
);

  logic               ex_load_live;
  logic [NUM_SRC-1:0] raw_hit;
  logic [NUM_SRC-1:0] use_hit;
  logic               stall_q;
  logic               stall_q_nxt;

  always_comb begin
    ex_load_live = ex_valid && ex_is_load;
  end

  // One comparator per decode source operand.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    hzd_reg_match #(.REG_W(REG_W)) u_match (
      .prod_valid(ex_load_live),
      .prod_wen  (ex_wen),
      .prod_rd   (ex_rd),
      .src_rs    (id_rs[g]),
      .hit       (raw_hit[g])
    );
    always_comb begin
      use_hit[g] = raw_hit[g] && id_use[g];
    end
  end

  // The cycle after a stall holds the same decode instruction behind a bubble,
  // so a repeat request is suppressed.
  always_comb begin
    stall       = (|use_hit) && !stall_q;
    stall_q_nxt = stall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= 1'b0;
    end else begin
      stall_q <= stall_q_nxt;
    end
  end

  AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall); // R9
  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ex_valid && ex_is_load && ex_wen && ex_rd != '0)); // R8
  AST_STALL_NEEDS_USE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (|id_use)); // R8

endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_use_rs1,
  input  logic             id_use_rs2,
  input  logic             ex_valid,
  input  logic [REG_W-1:0] ex_rs1,
  input  logic [REG_W-1:0] ex_rs2,
  input  logic             ex_wen,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             mem_valid,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             wb_valid,
  input  logic             wb_wen,
  input  logic [REG_W-1:0] wb_rd,
  output logic [1:0]       fwd_sel_a,
  output logic [1:0]       fwd_sel_b,
  output logic             id_wb_byp_a,
  output logic             id_wb_byp_b,
  output logic             hold_pc,
  output logic             hold_ifid,
  output logic             bubble_ex
);
  import fwd_pkg::*;

  localparam int OPS = NUM_OPS;

  logic [OPS-1:0][REG_W-1:0] id_rs_v;
  logic [OPS-1:0][REG_W-1:0] ex_rs_v;
  logic [OPS-1:0]            id_use_v;
  logic [OPS-1:0]            byp_v;
  fwd_sel_e                  sel_v [OPS];
  logic                      stall;

  always_comb begin
    id_rs_v  = {id_rs2, id_rs1};
    ex_rs_v  = {ex_rs2, ex_rs1};
    id_use_v = {id_use_rs2, id_use_rs1};
  end

  for (genvar g = 0; g < OPS; g++) begin : g_op
    hzd_operand_ctl #(.REG_W(REG_W)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ex_valid (ex_valid),
      .src_rs   (ex_rs_v[g]),
      .mem_valid(mem_valid),
      .mem_wen  (mem_wen),
      .mem_rd   (mem_rd),
      .wb_valid (wb_valid),
      .wb_wen   (wb_wen),
      .wb_rd    (wb_rd),
      .sel      (sel_v[g])
    );

    // Same-cycle write/read of the register file in decode.
    hzd_reg_match #(.REG_W(REG_W)) u_id_byp (
      .prod_valid(wb_valid),
      .prod_wen  (wb_wen),
      .prod_rd   (wb_rd),
      .src_rs    (id_rs_v[g]),
      .hit       (byp_v[g])
    );
  end

  hzd_loaduse_det #(.REG_W(REG_W), .NUM_SRC(OPS)) u_loaduse (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_rs     (id_rs_v),
    .id_use    (id_use_v),
    .ex_valid  (ex_valid),
    .ex_wen    (ex_wen),
    .ex_is_load(ex_is_load),
    .ex_rd     (ex_rd),
    .stall     (stall)
  );

  always_comb begin
    fwd_sel_a   = sel_v[0];
    fwd_sel_b   = sel_v[1];
    id_wb_byp_a = byp_v[0];
    id_wb_byp_b = byp_v[1];
    hold_pc     = stall;
    hold_ifid   = stall;
    bubble_ex   = stall;
  end

  AST_BYP_A_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    id_wb_byp_a |-> (wb_valid && wb_wen && wb_rd == id_rs1 && wb_rd != '0)); // R6
  AST_BYP_B_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    id_wb_byp_b |-> (wb_valid && wb_wen && wb_rd == id_rs2 && wb_rd != '0)); // R6
  AST_HOLD_BUBBLE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_ex |-> (hold_pc && hold_ifid)); // R7

endmodule

// File: tb/fwd_hazard_unit_tb_top.sv
`timescale 1ns/1ps
module fwd_hazard_unit_tb_top;

  localparam int RW = 5;

  logic clk;
  logic rst_n;
  logic [RW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic id_use_rs1, id_use_rs2, ex_valid, ex_wen, ex_is_load;
  logic mem_valid, mem_wen, wb_valid, wb_wen;
  logic [1:0] fwd_sel_a, fwd_sel_b;
  logic id_wb_byp_a, id_wb_byp_b, hold_pc, hold_ifid, bubble_ex;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  bit ref_prev_stall = 0;
  string tag_override = "";

  fwd_hazard_unit #(.REG_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
    .ex_valid(ex_valid), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_wen(ex_wen),
    .ex_is_load(ex_is_load), .ex_rd(ex_rd),
    .mem_valid(mem_valid), .mem_wen(mem_wen), .mem_rd(mem_rd),
    .wb_valid(wb_valid), .wb_wen(wb_wen), .wb_rd(wb_rd),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
    .id_wb_byp_a(id_wb_byp_a), .id_wb_byp_b(id_wb_byp_b),
    .hold_pc(hold_pc), .hold_ifid(hold_ifid), .bubble_ex(bubble_ex)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- reference model ----------------
  function automatic bit mem_m(logic [RW-1:0] rs);
    return mem_valid && mem_wen && mem_rd != 0 && mem_rd == rs;
  endfunction
  function automatic bit wb_m(logic [RW-1:0] rs);
    return wb_valid && wb_wen && wb_rd != 0 && wb_rd == rs;
  endfunction
  function automatic int m_sel(logic [RW-1:0] rs);
    if (!ex_valid) return 0;
    if (mem_m(rs)) return 1;
    if (wb_m(rs))  return 2;
    return 0;
  endfunction
  function automatic string sel_tag(logic [RW-1:0] rs);
    if (tag_override != "") return tag_override;
    if (!ex_valid) return "R5";
    if (mem_m(rs) && wb_m(rs)) return "R3";
    if (mem_m(rs)) return "R1";
    if (wb_m(rs))  return "R2";
    return "R4";
  endfunction
  function automatic bit m_stall();
    bit ld;
    ld = ex_valid && ex_is_load && ex_wen && ex_rd != 0;
    return ld && ((id_use_rs1 && id_rs1 == ex_rd) || (id_use_rs2 && id_rs2 == ex_rd))
           && !ref_prev_stall;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  bit exp_stall;

  // Inputs are set just after a falling edge; outputs checked 1 ns later.
  task automatic run_cycle();
    string st;
    if (!rst_n) ref_prev_stall = 0;
    #1;
    exp_stall = m_stall();
    chk(sel_tag(ex_rs1), "fwd_sel_a", fwd_sel_a, m_sel(ex_rs1));
    chk(sel_tag(ex_rs2), "fwd_sel_b", fwd_sel_b, m_sel(ex_rs2));
    chk(tag_override != "" ? tag_override : "R6", "id_wb_byp_a", id_wb_byp_a, wb_m(id_rs1));
    chk(tag_override != "" ? tag_override : "R6", "id_wb_byp_b", id_wb_byp_b, wb_m(id_rs2));
    if (tag_override != "") st = tag_override;
    else if (ref_prev_stall) st = "R9";
    else if (exp_stall) st = "R7";
    else st = "R8";
    chk(st, "hold_pc", hold_pc, exp_stall);
    chk(st, "hold_ifid", hold_ifid, exp_stall);
    chk(st, "bubble_ex", bubble_ex, exp_stall);
    @(posedge clk);
    ref_prev_stall = rst_n ? exp_stall : 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_inputs();
    id_rs1 = 0; id_rs2 = 0; id_use_rs1 = 0; id_use_rs2 = 0;
    ex_valid = 0; ex_rs1 = 0; ex_rs2 = 0; ex_wen = 0; ex_is_load = 0; ex_rd = 0;
    mem_valid = 0; mem_wen = 0; mem_rd = 0; wb_valid = 0; wb_wen = 0; wb_rd = 0;
  endtask

  task automatic set_load_use();
    ex_valid = 1; ex_is_load = 1; ex_wen = 1; ex_rd = 5'd7;
    id_rs1 = 5'd7; id_use_rs1 = 1; id_rs2 = 5'd3; id_use_rs2 = 1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    clear_inputs();
    @(negedge clk);
    tag_override = "R10";
    run_cycle();
    run_cycle();
    rst_n = 1;
    run_cycle();                         // R10 idle state after release
    tag_override = "";

    // R1: memory-stage match on operand A
    ex_valid = 1; ex_rs1 = 5'd4; ex_rs2 = 5'd9;
    mem_valid = 1; mem_wen = 1; mem_rd = 5'd4;
    run_cycle();
    // R2: writeback match on operand B
    clear_inputs(); ex_valid = 1; ex_rs1 = 5'd1; ex_rs2 = 5'd12;
    wb_valid = 1; wb_wen = 1; wb_rd = 5'd12;
    run_cycle();
    // R3: both stages match operand A and B
    clear_inputs(); ex_valid = 1; ex_rs1 = 5'd6; ex_rs2 = 5'd6;
    mem_valid = 1; mem_wen = 1; mem_rd = 5'd6;
    wb_valid = 1; wb_wen = 1; wb_rd = 5'd6;
    run_cycle();
    // R4: register 0, write disabled, invalid producer
    clear_inputs(); ex_valid = 1;
    mem_valid = 1; mem_wen = 1; mem_rd = 0; wb_valid = 1; wb_wen = 1; wb_rd = 0;
    run_cycle();
    ex_rs1 = 5'd5; ex_rs2 = 5'd8; mem_rd = 5'd5; mem_wen = 0; wb_rd = 5'd8; wb_valid = 0;
    run_cycle();
    // R5: execute idle
    clear_inputs(); ex_rs1 = 5'd2; mem_valid = 1; mem_wen = 1; mem_rd = 5'd2;
    run_cycle();
    // R6: decode same-cycle bypass
    clear_inputs(); id_rs1 = 5'd11; id_rs2 = 5'd11; wb_valid = 1; wb_wen = 1; wb_rd = 5'd11;
    run_cycle();
    // R7 then R9: stall once, suppressed next cycle, then allowed again
    clear_inputs(); set_load_use();
    run_cycle();
    run_cycle();
    run_cycle();
    // R8: source unused, and non-load producer
    clear_inputs(); set_load_use(); id_use_rs1 = 0;
    run_cycle();
    id_use_rs1 = 1; ex_is_load = 0;
    run_cycle();
    // R7 on operand B (store data / branch compare)
    clear_inputs(); set_load_use(); id_rs1 = 5'd2; id_rs2 = 5'd7;
    run_cycle();
    // R10: stall, then reset clears the one-bubble memory
    clear_inputs(); set_load_use();
    run_cycle();
    rst_n = 0;
    tag_override = "R10";
    run_cycle();
    rst_n = 1;
    run_cycle();
    tag_override = "";

    // Mixed traffic with small register numbers
    for (int i = 0; i < 4000; i++) begin
      id_rs1 = RW'($urandom_range(3, 0)); id_rs2 = RW'($urandom_range(3, 0));
      id_use_rs1 = 1'($urandom_range(1, 0)); id_use_rs2 = 1'($urandom_range(1, 0));
      ex_valid = ($urandom_range(7, 0) != 0); ex_wen = ($urandom_range(3, 0) != 0);
      ex_is_load = 1'($urandom_range(1, 0)); ex_rd = RW'($urandom_range(3, 0));
      ex_rs1 = RW'($urandom_range(3, 0)); ex_rs2 = RW'($urandom_range(3, 0));
      mem_valid = ($urandom_range(3, 0) != 0); mem_wen = ($urandom_range(3, 0) != 0);
      mem_rd = RW'($urandom_range(3, 0));
      wb_valid = ($urandom_range(3, 0) != 0); wb_wen = ($urandom_range(3, 0) != 0);
      wb_rd = RW'($urandom_range(3, 0));
      run_cycle();
    end

    done = 1;
    summary();
    $finish;
  end

endmodule